// File: doc/BRIEF.md
# CAN Request Dispatcher

This block is the control sequencer of a small CAN node. It sits between a stand-alone CAN protocol controller, which it reaches through an SPI master that runs one register operation at a time, and a local ADC. It has two event sources. The first is an internal periodic tick. On each tick it samples analog channel 0 and queues the value for transmission with identifier 0x3FE. The second is the controller's active-low interrupt line. On that event it reads the controller's interrupt flags. If a message has arrived, it reads which acceptance filter matched and runs the action for that filter: read analog channel 1, read the three general-purpose inputs, or drive one of two digital outputs. It then sends a reply whose identifier is the request identifier with ID bit 3 set.

Every transmission follows the same pattern. The block writes the identifier high byte, the identifier low byte and data byte 0 of transmit buffer 0, then issues a request-to-send command for that buffer. Invalid filters, bus errors and spurious interrupts each produce a system error frame with identifier 0x3FF and a one-byte code.

The state machine has these states:
- ST_IDLE: waiting for an event.
- ST_ADC: ADC conversion in progress.
- ST_RD_FLAGS, ST_RD_FILT, ST_RD_INPUTS, ST_RD_RXDATA: the four register reads.
- ST_SET_OUT: bit-modify of the output control register.
- ST_WR_IDH, ST_WR_IDL, ST_WR_DATA, ST_RTS: the reply frame.
- ST_CLEAR: flag clear.

The transitions are:
- ST_IDLE goes to ST_RD_FLAGS when an interrupt is pending. Otherwise it goes to ST_ADC when a tick is pending.
- ST_ADC goes to ST_WR_IDH.
- ST_RD_FLAGS goes to ST_RD_FILT when flag bit 1 is set. Otherwise it goes to ST_WR_IDH.
- ST_RD_FILT goes to ST_ADC (hit 2), ST_RD_INPUTS (hit 3), ST_RD_RXDATA (hit 4 or 5), or ST_WR_IDH (any other hit).
- ST_RD_INPUTS goes to ST_WR_IDH.
- ST_RD_RXDATA goes to ST_SET_OUT, and ST_SET_OUT goes to ST_WR_IDH.
- ST_WR_IDH goes to ST_WR_IDL, then ST_WR_DATA, then ST_RTS.
- ST_RTS goes to ST_CLEAR for interrupt work, or to ST_IDLE for tick work.
- ST_CLEAR goes to ST_IDLE.

Top module: `can_req_dispatch`

## Requirements
- R1: A tick occurs every PRESCALE*RELOAD clock cycles. Each tick converts ADC channel 0 (adc_chan=0) and transmits the result with identifier 0x3FE. Tick work performs no flag-clear operation.
- R2: Op kinds are encoded as READ=0, WRITE=1, BITMOD=2, RTS=3. A frame with identifier `id` and data `d` is sent as four operations in this order:
  - WRITE to address 0x31 with data id[10:3];
  - WRITE to address 0x32 with data {id[2:0],5'b0};
  - WRITE to address 0x36 with data d;
  - RTS with address 0.
- R3: A falling edge on can_int_n, after synchronisation, starts interrupt work. That work begins with a READ of the flag register at address 0x2C.
- R4: When flag bit 1 is set, the block READs address 0x70. Bits 2:0 of that register are the filter hit. Hits 2, 3, 4 and 5 stand for requests 0x3F0 to 0x3F3 respectively. The reply identifier is the request identifier OR 0x008.
- R5: Hit 2 converts ADC channel 1 and replies with identifier 0x3F8, carrying the converted value.
- R6: Hit 3 READs address 0x0D. It replies with identifier 0x3F9 and data {5'b0, rd[5:3]}.
- R7: Hits 4 and 5 READ address 0x76 and issue a BITMOD to address 0x0C, with mask 0x10 for hit 4 or 0x20 for hit 5. The BITMOD data is 0xFF if bit 0 of the read byte is set and 0x00 otherwise. The reply uses identifier 0x3FA or 0x3FB and carries {7'b0, bit0}.
- R8: Any other hit value (0, 1, 6, 7) sends identifier 0x3FF with code 0x03.
- R9: The flag bits are handled in priority order:
  - flag bit 1 takes priority, and bit 5 is then ignored;
  - otherwise bit 5 sends 0x3FF with code 0x01;
  - a flag byte with neither bit set sends 0x3FF with code 0x02.
- R10: Interrupt work ends after its RTS with a BITMOD to address 0x2C, mask 0x22, data 0x00.
- R11: A tick that arrives during interrupt work is held and serviced afterwards. An interrupt that arrives during tick work is serviced after that work completes.
- R12: During and after reset, op_valid and adc_req are low until an event occurs.
- R13: Only one operation is outstanding at a time:
  - op_valid holds its fields stable until op_done;
  - op_valid and adc_req are never both high;
  - unused fields are zero (wdata and mask for READ and RTS, mask for WRITE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| can_int_n | input | 1 | Active-low interrupt from CAN controller, asynchronous |
| op_valid | output | 1 | Register operation request to SPI master |
| op_kind | output | 2 | 0 read, 1 write, 2 bit-modify, 3 request-to-send |
| op_addr | output | 8 | Controller register address |
| op_wdata | output | 8 | Write or bit-modify data |
| op_mask | output | 8 | Bit-modify mask |
| op_done | input | 1 | One-cycle completion pulse from SPI master |
| op_rdata | input | 8 | Read data, valid with op_done |
| adc_req | output | 1 | Conversion request, held until adc_done |
| adc_chan | output | 1 | Channel to convert |
| adc_done | input | 1 | One-cycle conversion complete pulse |
| adc_value | input | 8 | Conversion result, valid with adc_done |

## Verification
The bench builds the block with PRESCALE=8 and RELOAD=25, which gives a tick every 200 cycles. At that period, an interrupt sequence fits between two ticks, and a tick can be placed deliberately inside an interrupt sequence. The bench sweeps all eight filter-hit values and both values of the output data bit. It also drives the bus-error, spurious and priority flag combinations. Each case is compared operation by operation against a log computed from the encodings in the requirements.

// File: rtl/can_disp_pkg.sv
package can_disp_pkg;
    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_BITMOD = 2'd2,
        OP_RTS    = 2'd3
    } op_kind_e;

    // controller register addresses the sequence depends on
    localparam logic [7:0] ADDR_IRQ_FLAGS = 8'h2C;
    localparam logic [7:0] ADDR_RX_CTRL   = 8'h70;
    localparam logic [7:0] ADDR_IN_CTRL   = 8'h0D;
    localparam logic [7:0] ADDR_RX_DATA0  = 8'h76;
    localparam logic [7:0] ADDR_OUT_CTRL  = 8'h0C;
    localparam logic [7:0] ADDR_TX_IDH    = 8'h31;
    localparam logic [7:0] ADDR_TX_IDL    = 8'h32;
    localparam logic [7:0] ADDR_TX_DATA0  = 8'h36;

    localparam int FLAG_RX_BIT  = 1;
    localparam int FLAG_ERR_BIT = 5;
    localparam logic [7:0] CLEAR_MASK = 8'h22;

    localparam logic [7:0] MASK_OUT_A = 8'h10;
    localparam logic [7:0] MASK_OUT_B = 8'h20;

    localparam logic [10:0] ID_REQ_BASE = 11'h3F0;
    localparam logic [10:0] ID_REPLY_BIT = 11'h008;
    localparam logic [10:0] ID_PERIODIC = 11'h3FE;
    localparam logic [10:0] ID_SYS_ERR  = 11'h3FF;

    localparam logic [7:0] CODE_BUS_ERR  = 8'h01;
    localparam logic [7:0] CODE_BAD_IRQ  = 8'h02;
    localparam logic [7:0] CODE_BAD_HIT  = 8'h03;
endpackage

// File: rtl/cdisp_tick_gen.sv
module cdisp_tick_gen #(
    parameter int PRESCALE = 256,
    parameter int RELOAD   = 38
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int RW = (RELOAD > 1) ? $clog2(RELOAD) : 1;

    logic [PW-1:0] pre_cnt;
    logic [RW-1:0] per_cnt;
    logic          pre_wrap;
    logic          per_wrap;

    assign pre_wrap = (pre_cnt == PW'(PRESCALE - 1));
    assign per_wrap = (per_cnt == RW'(RELOAD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            per_cnt <= '0;
            tick_o  <= 1'b0;
        end else begin
            tick_o  <= pre_wrap && per_wrap;
            pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
            if (pre_wrap) begin
                per_cnt <= per_wrap ? '0 : per_cnt + 1'b1;
            end
        end
    end

    // R1: a tick is a single-cycle pulse
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/cdisp_irq_edge.sv
module cdisp_irq_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], irq_n_i};
            prev_q <= cur;
        end
    end

    assign fall_o = prev_q && !cur;

    // R3: one event per falling edge
    a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/cdisp_fsm.sv
module cdisp_fsm
    import can_disp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       irq_fall_i,
    output logic       op_valid,
    output op_kind_e   op_kind,
    output logic [7:0] op_addr,
    output logic [7:0] op_wdata,
    output logic [7:0] op_mask,
    input  logic       op_done,
    input  logic [7:0] op_rdata,
    output logic       adc_req,
    output logic       adc_chan,
    input  logic       adc_done,
    input  logic [7:0] adc_value
);
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADC, ST_RD_FLAGS, ST_RD_FILT, ST_RD_INPUTS,
        ST_RD_RXDATA, ST_SET_OUT, ST_WR_IDH, ST_WR_IDL, ST_WR_DATA,
        ST_RTS, ST_CLEAR
    } state_e;

    state_e      state, nxt;
    logic        tick_pend, irq_pend, in_irq;
    logic        take_irq, take_tick;
    logic [10:0] rid;
    logic [7:0]  rdat;
    logic [7:0]  out_mask;
    logic [1:0]  hit_off;

    assign take_irq  = (state == ST_IDLE) && irq_pend;
    assign take_tick = (state == ST_IDLE) && !irq_pend && tick_pend;
    assign hit_off   = op_rdata[1:0] - 2'd2;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (irq_pend)       nxt = ST_RD_FLAGS;
                else if (tick_pend) nxt = ST_ADC;
            end
            ST_ADC:       if (adc_done) nxt = ST_WR_IDH;
            ST_RD_FLAGS:  if (op_done)  nxt = op_rdata[FLAG_RX_BIT] ? ST_RD_FILT : ST_WR_IDH;
            ST_RD_FILT: begin
                if (op_done) begin
                    unique case (op_rdata[2:0])
                        3'd2:       nxt = ST_ADC;
                        3'd3:       nxt = ST_RD_INPUTS;
                        3'd4, 3'd5: nxt = ST_RD_RXDATA;
                        default:    nxt = ST_WR_IDH;
                    endcase
                end
            end
            ST_RD_INPUTS: if (op_done) nxt = ST_WR_IDH;
            ST_RD_RXDATA: if (op_done) nxt = ST_SET_OUT;
            ST_SET_OUT:   if (op_done) nxt = ST_WR_IDH;
            ST_WR_IDH:    if (op_done) nxt = ST_WR_IDL;
            ST_WR_IDL:    if (op_done) nxt = ST_WR_DATA;
            ST_WR_DATA:   if (op_done) nxt = ST_RTS;
            ST_RTS:       if (op_done) nxt = in_irq ? ST_CLEAR : ST_IDLE;
            ST_CLEAR:     if (op_done) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // event pending flags and reply context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_pend <= 1'b0;
            irq_pend  <= 1'b0;
            in_irq    <= 1'b0;
            adc_chan  <= 1'b0;
            rid       <= '0;
            rdat      <= '0;
            out_mask  <= '0;
        end else begin
            tick_pend <= (tick_pend && !take_tick) || tick_i;
            irq_pend  <= (irq_pend && !take_irq) || irq_fall_i;
            if (take_irq) in_irq <= 1'b1;
            if (take_tick) begin
                in_irq   <= 1'b0;
                adc_chan <= 1'b0;
                rid      <= ID_PERIODIC;
            end
            if (state == ST_ADC && adc_done) rdat <= adc_value;
            if (state == ST_RD_FLAGS && op_done && !op_rdata[FLAG_RX_BIT]) begin
                rid  <= ID_SYS_ERR;
                rdat <= op_rdata[FLAG_ERR_BIT] ? CODE_BUS_ERR : CODE_BAD_IRQ;
            end
            if (state == ST_RD_FILT && op_done) begin
                rid <= ID_REQ_BASE | ID_REPLY_BIT | {9'b0, hit_off};
                unique case (op_rdata[2:0])
                    3'd2:    adc_chan <= 1'b1;
                    3'd3:    ;
                    3'd4:    out_mask <= MASK_OUT_A;
                    3'd5:    out_mask <= MASK_OUT_B;
                    default: begin
                        rid  <= ID_SYS_ERR;
                        rdat <= CODE_BAD_HIT;
                    end
                endcase
            end
            if (state == ST_RD_INPUTS && op_done) rdat <= {5'b0, op_rdata[5:3]};
            if (state == ST_RD_RXDATA && op_done) rdat <= {7'b0, op_rdata[0]};
        end
    end

    // outputs
    always_comb begin
        op_valid = 1'b0;
        op_kind  = OP_READ;
        op_addr  = '0;
        op_wdata = '0;
        op_mask  = '0;
        adc_req  = 1'b0;
        unique case (state)
            ST_ADC:       adc_req = 1'b1;
            ST_RD_FLAGS:  begin op_valid = 1'b1; op_addr = ADDR_IRQ_FLAGS; end
            ST_RD_FILT:   begin op_valid = 1'b1; op_addr = ADDR_RX_CTRL;   end
            ST_RD_INPUTS: begin op_valid = 1'b1; op_addr = ADDR_IN_CTRL;   end
            ST_RD_RXDATA: begin op_valid = 1'b1; op_addr = ADDR_RX_DATA0;  end
            ST_SET_OUT: begin
                op_valid = 1'b1; op_kind = OP_BITMOD; op_addr = ADDR_OUT_CTL_FIX;
                op_mask  = out_mask; op_wdata = {8{rdat[0]}};
            end
            ST_WR_IDH: begin
                op_valid = 1'b1; op_kind = OP_WRITE; op_addr = ADDR_TX_IDH;
                op_wdata = rid[10:3];
            end
            ST_WR_IDL: begin
                op_valid = 1'b1; op_kind = OP_WRITE; op_addr = ADDR_TX_IDL;
                op_wdata = {rid[2:0], 5'b0};
            end
            ST_WR_DATA: begin
                op_valid = 1'b1; op_kind = OP_WRITE; op_addr = ADDR_TX_DATA0;
                op_wdata = rdat;
            end
            ST_RTS:   begin op_valid = 1'b1; op_kind = OP_RTS; end
            ST_CLEAR: begin
                op_valid = 1'b1; op_kind = OP_BITMOD; op_addr = ADDR_IRQ_FLAGS;
                op_mask  = CLEAR_MASK;
            end
            default: ;
        endcase
    end

    localparam logic [7:0] ADDR_OUT_CTL_FIX = ADDR_OUT_CTRL;

    // R11: a tick arriving mid-sequence stays pending until idle
    a_r11_tick_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_pend && state != ST_IDLE) |=> tick_pend);

    // R13: request fields hold until completion
    a_r13_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_done) |=> (op_valid && $stable(op_addr) && $stable(op_kind)
                                    && $stable(op_wdata)));

    // R13: never an SPI operation and a conversion at once
    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && adc_req));

    // R7: output update touches one bit with a uniform data byte
    a_r7_out_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_BITMOD && op_addr == ADDR_OUT_CTRL) |->
            ($countones(op_mask) == 1 && (op_wdata == 8'hFF || op_wdata == 8'h00)));

    // R2: every transmitted identifier lies in 0x3F8..0x3FF
    a_r2_id_high: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_WRITE && op_addr == ADDR_TX_IDH) |-> op_wdata == 8'h7F);
endmodule

// File: rtl/can_req_dispatch.sv
module can_req_dispatch #(
    parameter int PRESCALE    = 256,
    parameter int RELOAD      = 38,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       can_int_n,
    output logic       op_valid,
    output logic [1:0] op_kind,
    output logic [7:0] op_addr,
    output logic [7:0] op_wdata,
    output logic [7:0] op_mask,
    input  logic       op_done,
    input  logic [7:0] op_rdata,
    output logic       adc_req,
    output logic       adc_chan,
    input  logic       adc_done,
    input  logic [7:0] adc_value
);
    import can_disp_pkg::*;

    logic     tick;
    logic     irq_fall;
    op_kind_e kind;

    cdisp_tick_gen #(.PRESCALE(PRESCALE), .RELOAD(RELOAD)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    cdisp_irq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .irq_n_i(can_int_n), .fall_o(irq_fall)
    );

    cdisp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .irq_fall_i(irq_fall),
        .op_valid(op_valid), .op_kind(kind), .op_addr(op_addr),
        .op_wdata(op_wdata), .op_mask(op_mask), .op_done(op_done),
        .op_rdata(op_rdata), .adc_req(adc_req), .adc_chan(adc_chan),
        .adc_done(adc_done), .adc_value(adc_value)
    );

    assign op_kind = kind;
endmodule

// File: tb/can_req_dispatch_tb.sv
`timescale 1ns/1ps
module can_req_dispatch_tb_top;
    localparam int PRE = 8;
    localparam int REL = 25;
    localparam int PERIOD = PRE * REL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       can_int_n = 1'b1;
    logic       op_valid;
    logic [1:0] op_kind;
    logic [7:0] op_addr, op_wdata, op_mask;
    logic       op_done = 1'b0;
    logic [7:0] op_rdata = 8'h00;
    logic       adc_req, adc_chan;
    logic       adc_done = 1'b0;
    logic [7:0] adc_value = 8'h00;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t_prev = 0, t_last = 0;

    logic [7:0] m_flags, m_filt, m_inputs, m_rxd;
    logic [7:0] v0 = 8'h5A, v1 = 8'hC3;

    logic [25:0] log_q [64];
    int          log_n = 0;
    logic [25:0] exp_q [64];
    int          exp_n = 0;

    can_req_dispatch #(.PRESCALE(PRE), .RELOAD(REL), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .can_int_n(can_int_n),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .op_wdata(op_wdata), .op_mask(op_mask), .op_done(op_done),
        .op_rdata(op_rdata), .adc_req(adc_req), .adc_chan(adc_chan),
        .adc_done(adc_done), .adc_value(adc_value)
    );

    initial forever #2.5 clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    // SPI master and controller register model
    initial begin
        bit busy = 0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (op_done) op_done = 1'b0;
            else if (busy) begin
                if (cnt == 0) begin
                    busy = 0;
                    op_done = 1'b1;
                    if (log_n < 64) log_q[log_n] = {op_kind, op_addr, op_wdata, op_mask};
                    log_n++;
                    case (op_addr)
                        8'h2C: op_rdata = m_flags;
                        8'h70: op_rdata = m_filt;
                        8'h0D: op_rdata = m_inputs;
                        8'h76: op_rdata = m_rxd;
                        default: op_rdata = 8'h00;
                    endcase
                    if (op_kind == 2'd2 && op_addr == 8'h2C) can_int_n = 1'b1;
                end else cnt--;
            end else if (op_valid) begin
                busy = 1; cnt = 1;
            end
        end
    end

    // ADC model
    initial begin
        bit busy = 0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (adc_done) adc_done = 1'b0;
            else if (busy) begin
                if (cnt == 0) begin
                    busy = 0; adc_done = 1'b1;
                    adc_value = adc_chan ? v1 : v0;
                end else cnt--;
            end else if (adc_req) begin
                busy = 1; cnt = 2;
                if (!adc_chan) begin t_prev = t_last; t_last = cyc; end
            end
        end
    end

    function automatic void push(input logic [1:0] k, input logic [7:0] a,
                                 input logic [7:0] d, input logic [7:0] m);
        exp_q[exp_n] = {k, a, d, m};
        exp_n++;
    endfunction

    function automatic void push_frame(input logic [10:0] id, input logic [7:0] d);
        push(2'd1, 8'h31, id[10:3], 8'h00);
        push(2'd1, 8'h32, {id[2:0], 5'b0}, 8'h00);
        push(2'd1, 8'h36, d, 8'h00);
        push(2'd3, 8'h00, 8'h00, 8'h00);
    endfunction

    function automatic void push_irq(input logic [7:0] fl, input logic [7:0] fi,
                                     input logic [7:0] inp, input logic [7:0] rx);
        push(2'd0, 8'h2C, 8'h00, 8'h00);
        if (fl[1]) begin
            push(2'd0, 8'h70, 8'h00, 8'h00);
            case (fi[2:0])
                3'd2: push_frame(11'h3F8, v1);
                3'd3: begin
                    push(2'd0, 8'h0D, 8'h00, 8'h00);
                    push_frame(11'h3F9, {5'b0, inp[5:3]});
                end
                3'd4, 3'd5: begin
                    push(2'd0, 8'h76, 8'h00, 8'h00);
                    push(2'd2, 8'h0C, rx[0] ? 8'hFF : 8'h00, fi[2:0] == 3'd4 ? 8'h10 : 8'h20);
                    push_frame(fi[2:0] == 3'd4 ? 11'h3FA : 11'h3FB, {7'b0, rx[0]});
                end
                default: push_frame(11'h3FF, 8'h03);
            endcase
        end else if (fl[5]) push_frame(11'h3FF, 8'h01);
        else push_frame(11'h3FF, 8'h02);
        push(2'd2, 8'h2C, 8'h00, 8'h22);
    endfunction

    task automatic check_log(input string tag);
        checks++;
        if (log_n != exp_n) begin
            errors++;
            $display("FAIL %s: op count actual %0d expected %0d", tag, log_n, exp_n);
        end else begin
            for (int i = 0; i < exp_n; i++) begin
                if (log_q[i] !== exp_q[i]) begin
                    errors++;
                    $display("FAIL %s: op %0d actual %h expected %h", tag, i, log_q[i], exp_q[i]);
                    break;
                end
            end
        end
    endtask

    task automatic sync_tick();
        @(posedge clk);
        log_n = 0; exp_n = 0;
        push_frame(11'h3FE, v0);
        wait (log_n >= 4);
        repeat (3) @(posedge clk);
        check_log("R1 R2 R10 tick report");
    endtask

    task automatic run_irq(input logic [7:0] fl, input logic [7:0] fi,
                           input logic [7:0] inp, input logic [7:0] rx, input string tag);
        sync_tick();
        m_flags = fl; m_filt = fi; m_inputs = inp; m_rxd = rx;
        @(posedge clk);
        log_n = 0; exp_n = 0;
        push_irq(fl, fi, inp, rx);
        @(negedge clk); can_int_n = 1'b0;
        repeat (110) @(posedge clk);
        check_log(tag);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_flags = 0; m_filt = 0; m_inputs = 0; m_rxd = 0;
        // R12 reset state
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (op_valid !== 1'b0 || adc_req !== 1'b0) begin
                errors++;
                $display("FAIL R12: op_valid=%b adc_req=%b expected 0 0", op_valid, adc_req);
            end
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (op_valid !== 1'b0 || adc_req !== 1'b0) begin
            errors++;
            $display("FAIL R12: after reset op_valid=%b adc_req=%b expected 0 0", op_valid, adc_req);
        end

        sync_tick();
        sync_tick();
        checks++;
        if (t_last - t_prev != PERIOD) begin
            errors++;
            $display("FAIL R1: tick period actual %0d expected %0d", t_last - t_prev, PERIOD);
        end

        // sweep every filter-hit value, junk in upper bits of the control byte
        for (int f = 0; f < 8; f++) begin
            logic [7:0] fi;
            fi = 8'hA8 | 8'(f);
            case (f)
                2: run_irq(8'h02, fi, 8'h00, 8'h00, "R3 R4 R5 analog read");
                3: begin
                    run_irq(8'h02, fi, 8'hE8, 8'h00, "R4 R6 inputs 101");
                    run_irq(8'h02, fi, 8'h17, 8'h00, "R6 inputs 010");
                end
                4, 5: begin
                    run_irq(8'h02, fi, 8'h00, 8'hFE, "R7 output clear");
                    run_irq(8'h02, fi, 8'h00, 8'h01, "R7 output set");
                end
                default: run_irq(8'h02, fi, 8'h00, 8'h00, "R8 bad filter");
            endcase
        end

        run_irq(8'h20, 8'h02, 8'h00, 8'h00, "R9 bus error");
        run_irq(8'h00, 8'h02, 8'h00, 8'h00, "R9 R13 spurious interrupt");
        run_irq(8'hDD, 8'h02, 8'h00, 8'h00, "R9 spurious with other bits");
        run_irq(8'h22, 8'h03, 8'h38, 8'h00, "R9 R10 receive beats error");

        // R11: tick arrives during interrupt work
        sync_tick();
        begin
            int target;
            target = t_last + PERIOD - 10;
            m_flags = 8'h02; m_filt = 8'h03; m_inputs = 8'h28;
            wait (cyc >= target);
            @(posedge clk);
            log_n = 0; exp_n = 0;
            push_irq(8'h02, 8'h03, 8'h28, 8'h00);
            push_frame(11'h3FE, v0);
            @(negedge clk); can_int_n = 1'b0;
            repeat (150) @(posedge clk);
            check_log("R11 tick held during interrupt");
        end

        // R11: interrupt arrives during tick work
        m_flags = 8'h02; m_filt = 8'h02;
        @(posedge clk);
        log_n = 0; exp_n = 0;
        push_frame(11'h3FE, v0);
        push_irq(8'h02, 8'h02, 8'h00, 8'h00);
        wait (adc_req && !adc_chan);
        @(negedge clk); can_int_n = 1'b0;
        repeat (120) @(posedge clk);
        check_log("R11 interrupt held during tick");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule